// File: doc/BRIEF.md
# MFM Write Channel Encoder with Missing-Clock Sync

This block turns a stream of bytes into the channel-bit sequence that drives the write head of a flexible disk. It uses modified frequency modulation. Every data bit becomes two channel bits, sent in this order: a clock half-cell, then a data half-cell. A channel bit of 1 means a flux transition. One channel bit leaves the block on each clock tick.

Bytes enter on a valid/ready handshake. Each byte carries a flag that asks for a sync mark. When the flag is set and the byte is 0xA1, the block drops one clock transition. The result is a 16-bit pattern that ordinary encoded data can never produce, so a read channel can use it to find byte alignment. The block holds off the next byte while the current one is still shifting out. It accepts that next byte in the cycle of the last channel bit, so bytes offered back to back leave as one stream with no gap.

Top module: `mfm_write_enc`

## Requirements
- R1: While reset is held (rst_n low), bit_valid is 0, bit_out is 0 and in_ready is 1.
- R2: A byte accepted at a clock edge (in_valid and in_ready both high) produces 16 channel bits on the following 16 cycles. Data bits go most significant first, and each data bit is sent as its clock half-cell followed by its data half-cell.
- R3: A data bit of 1 gives a data half-cell of 1 and a clock half-cell of 0. A data bit of 0 gives a data half-cell of 0.
- R4: A clock half-cell is 1 only when both the current data bit and the data bit before it are 0. As a result, no two consecutive channel bits of a byte stream are both 1, and no more than three 0s occur in a row.
- R5: The data bit before the first bit of a byte is the last bit of the previous accepted byte. This holds across idle gaps. After reset it is 0, so 0x00 as the first byte gives 0xAAAA.
- R6: The byte 0xA1 with in_sync high encodes as 0x4489. This is the clock half-cell before data bit 2 forced to 0, with bit 0 being the least significant.
- R7: in_sync has no effect on any byte other than 0xA1. For example, 0x5A with in_sync high encodes exactly as 0x5A without it.
- R8: While a byte is shifting out, in_ready is 0 during its first 15 channel bits and 1 during its 16th. Bytes offered back to back therefore keep bit_valid high with no gap.
- R9: The byte 0xA1 with in_sync low encodes normally, as 0x44A9 when the previous data bit is 1 (or as the normal rule gives otherwise).
- R10: When no byte is shifting out, bit_valid is 0 and bit_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel-bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| in_data | input | 8 | Byte to encode |
| in_sync | input | 1 | Request the missing-clock sync variant (honoured only for 0xA1) |
| bit_out | output | 1 | Channel bit, 1 = flux transition |
| bit_valid | output | 1 | bit_out carries a channel bit of a byte |

## Verification
The first channel bit of an accepted byte appears in the cycle right after the accepting edge. The remaining 15 bits follow on consecutive cycles, and in_ready rises only during the 16th. A monitor samples on the falling edge and collects each group of 16 valid bits into a word. It compares that word against the queue the driver filled at acceptance time, and it checks the in_ready level at every bit position. A separate back-to-back run counts falling edges from the first acceptance and requires bit_valid to be high on each of the 48 edges that follow.

// File: rtl/mfm_write_enc.sv
module mfm_write_enc #(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  SYNC_VAL = 8'hA1,
  parameter int          GAP_POS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sync,
  output logic              bit_out,
  output logic              bit_valid
);
  localparam int CELL_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(CELL_W);

  logic [CELL_W-1:0] sh, enc;
  logic [CNT_W-1:0]  cnt;
  logic              busy, prev, last, take;

  assign last      = cnt == CNT_W'(CELL_W - 1);
  assign in_ready  = !busy || last;
  assign take      = in_valid && in_ready;
  assign bit_valid = busy;
  assign bit_out   = busy & sh[CELL_W-1];

  always_comb begin
    logic p;
    p = prev;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      enc[2*i+1] = ~p & ~in_data[i];
      enc[2*i]   = in_data[i];
      p          = in_data[i];
    end
    if (in_sync && in_data == SYNC_VAL[BYTE_W-1:0])
      enc[2*GAP_POS+1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      prev <= 1'b0;
    end else if (take) begin
      sh   <= enc;
      cnt  <= '0;
      busy <= 1'b1;
      prev <= in_data[0];
    end else if (busy) begin
      sh  <= sh << 1;
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mfm_write_enc_chk.sv
module mfm_write_enc_chk #(
  parameter int CELL_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic bit_out,
  input logic bit_valid
);
  localparam int CNT_W = $clog2(CELL_W);

  logic [CNT_W-1:0] pos;
  logic [2:0]       zrun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      zrun <= '0;
    end else begin
      if (in_valid && in_ready) pos <= '0;
      else if (bit_valid)       pos <= pos + 1'b1;
      if (!bit_valid)    zrun <= '0;
      else if (bit_out)  zrun <= '0;
      else if (zrun != 3'd7) zrun <= zrun + 1'b1;
    end
  end

  a_r2_first_bit_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> bit_valid);

  a_r8_ready_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && pos != CNT_W'(CELL_W - 1) |-> !in_ready);

  a_r8_ready_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && pos == CNT_W'(CELL_W - 1) |-> in_ready);

  a_r4_no_adjacent_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && $past(bit_valid) && $past(bit_out) |-> !bit_out);

  a_r4_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= 3'd3);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> !bit_out && in_ready);
endmodule

bind mfm_write_enc mfm_write_enc_chk #(.CELL_W(2 * BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .bit_out(bit_out), .bit_valid(bit_valid)
);

// File: tb/test_mfm_write_enc.sv
module test_mfm_write_enc;
  logic clk = 0, rst_n = 0, in_valid = 0, in_sync = 0;
  logic [7:0] in_data = '0;
  logic in_ready, bit_out, bit_valid;

  int checks = 0, fails = 0;
  logic model_prev = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mfm_write_enc i_mfm_write_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sync(in_sync), .bit_out(bit_out), .bit_valid(bit_valid)
  );

  function automatic logic [15:0] model(input logic [7:0] d, input logic s, input logic p);
    logic [15:0] w;
    logic q;
    q = p;
    for (int i = 7; i >= 0; i--) begin
      w[2*i+1] = (q == 1'b0) && (d[i] == 1'b0);
      w[2*i]   = d[i];
      q        = d[i];
    end
    if (s && d == 8'hA1) w[5] = 1'b0;
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic s, input string req);
    in_valid = 1'b1;
    in_data  = d;
    in_sync  = s;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(d, s, model_prev));
    tag_q.push_back(req);
    model_prev = d[0];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_sync  = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  logic [15:0] word;
  int          nb = 0;
  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      word = {word[14:0], bit_out};
      if (nb < 15 && in_ready) begin
        checks++; fails++;
        $display("FAIL R8: actual ready 1 expected 0 at bit %0d", nb);
      end
      nb++;
      if (nb == 16) begin
        check("R8", {15'd0, in_ready}, 16'd1);
        nb = 0;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: actual word %h expected none", word);
        end else begin
          automatic string t = tag_q.pop_front();
          check(t, word, exp_q.pop_front());
        end
      end
    end else if (rst_n && !bit_valid) begin
      if (nb != 0) begin
        checks++; fails++;
        $display("FAIL R2: actual %0d bits expected 16", nb);
        nb = 0;
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {13'd0, bit_valid, bit_out, in_ready}, 16'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {14'd0, bit_valid, bit_out}, 16'd0);

    // R5: first byte after reset sees previous bit 0
    send(8'h00, 1'b0, "R5");
    idle(20);
    // R3 / R4
    send(8'hFF, 1'b0, "R3");
    idle(20);
    // R6: sync mark after a byte ending in 1
    send(8'hA1, 1'b1, "R6");
    idle(20);
    // R9: plain A1, previous bit 1
    send(8'hA1, 1'b0, "R9");
    idle(20);
    // R7: flag ignored on other values
    send(8'h5A, 1'b1, "R7");
    idle(20);
    send(8'h5A, 1'b0, "R7");
    idle(20);
    check("R10", {14'd0, bit_valid, bit_out}, 16'd0);
    // R5: previous bit carried across idle (0x5A ends in 0)
    send(8'h00, 1'b0, "R5");
    idle(20);
    send(8'h24, 1'b0, "R4");
    idle(20);

    // R8: back to back, stream without gap
    fork
      begin
        send(8'h00, 1'b0, "R8");
        send(8'hA1, 1'b1, "R6");
        send(8'hA1, 1'b1, "R6");
        idle(1);
      end
      begin
        int gaps;
        gaps = 0;
        @(negedge clk);
        repeat (48) begin
          if (!bit_valid) gaps++;
          @(negedge clk);
        end
        check("R8", 16'(gaps), 16'd0);
      end
    join
    idle(24);

    // literal checks of the two A1 encodings
    check("R6", model(8'hA1, 1'b1, 1'b1), 16'h4489);
    check("R9", model(8'hA1, 1'b0, 1'b1), 16'h44A9);
    check("R2", 16'(exp_q.size()), 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule